// File: doc/BRIEF.md
# Flash Strobe Pulse Timer

This block drives a single strobe pulse toward a flash unit once per captured frame. When the flash mode enable is set, a frame-start strobe opens the pulse. The pulse length is taken from an 8-bit length input, and one length step equals a fixed prescale of pixel-clock cycles (1024 by default). The block captures the length input on the frame-start strobe. A new value written between frames therefore takes effect on the next pulse without any further frame alignment. Before the first capture, the held length is 8.

The all-ones length is a special case: it does not select a width. With that value the pulse stays high until the readout-start strobe, which marks the first row being read, and then goes low. This gives the longest pulse the frame allows. For every other length, readout start still cuts the pulse short if it comes first. A length of zero gives no pulse. A frame start that arrives while a pulse is running restarts the pulse at its full new length. All pins are plain control pins with no handshake.

Top module: `flash_strobe_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `strobe_o` is low.
- R2: A frame start sampled with `flash_en_i` high and `len_i` in 1..254 drives `strobe_o` high from the next cycle for exactly `len_i`×PRESCALE cycles.
- R3: A frame start sampled with `len_i` equal to 0 leaves `strobe_o` low.
- R4: When `len_i` equals 255 (all ones), the pulse is not timed. It stays high until `readout_start_i` is sampled high and is low from the following cycle.
- R5: `readout_start_i` sampled high during a timed pulse ends the pulse in the following cycle, even if the programmed length has not run out.
- R6: While `flash_en_i` is low, frame starts are ignored. Dropping `flash_en_i` during a pulse ends the pulse in the following cycle.
- R7: The length is captured at frame start. A change of `len_i` during a pulse does not alter that pulse, and the new value sets the length of the next pulse.
- R8: A frame start sampled during a pulse (enable high, nonzero length) restarts the pulse. The prescaler and the step counter clear, so the pulse continues for the full new length from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_en_i | input | 1 | Flash mode enable |
| len_i | input | 8 | Pulse length in prescale steps; 255 means "until readout" |
| frame_start_i | input | 1 | One-cycle frame-start strobe |
| readout_start_i | input | 1 | One-cycle strobe marking readout of the first row |
| strobe_o | output | 1 | Flash strobe pulse |

## Verification
The bench uses a prescale of 2. It sweeps every length from 0 to 254 with no readout event, which confirms the exact step multiplication and the zero-length case at every value. The all-ones length is run with readout arriving early, mid-way and late, which tells the untimed hold apart from a timed width. Timed lengths are cut by readout one cycle before, exactly at and one cycle after their natural end, so early cut-off can be told from normal expiry. Further runs drop the enable mid-pulse, change the length mid-pulse, and restart a pulse with a second frame start; these separate capture-at-start from live use and restart from extension.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int unsigned DEF_LEN_W    = 8;
  localparam int unsigned DEF_PRESCALE = 1024;
  localparam int unsigned DEF_RST_LEN  = 8;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/flash_prescaler.sv
module flash_prescaler #(
  parameter int unsigned PRESCALE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = flash_pkg::cnt_width(PRESCALE);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (clr)        pre_q <= '0;
    else if (run)        pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign tick = run && !clr && (pre_q == LAST);
endmodule

// File: rtl/flash_step_counter.sv
module flash_step_counter #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic [LEN_W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_q <= '0;
    else if (clr)   step_q <= '0;
    else if (tick)  step_q <= step_q + 1'b1;
  end

  assign done = tick && (step_q == len - 1'b1);
endmodule

// File: rtl/flash_strobe_timer.sv
module flash_strobe_timer #(
  parameter int unsigned LEN_W    = flash_pkg::DEF_LEN_W,
  parameter int unsigned PRESCALE = flash_pkg::DEF_PRESCALE,
  parameter int unsigned RST_LEN  = flash_pkg::DEF_RST_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flash_en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             frame_start_i,
  input  logic             readout_start_i,
  output logic             strobe_o
);
  localparam logic [LEN_W-1:0] HOLD_CODE = '1;

  logic             active_q;
  logic [LEN_W-1:0] len_q;
  logic             arm;
  logic             tick;
  logic             done;

  // a frame start with the enable set re-captures length and clears timing
  assign arm = frame_start_i && flash_en_i;

  flash_prescaler #(.PRESCALE(PRESCALE)) prescale_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (arm),
    .run  (active_q),
    .tick (tick)
  );

  flash_step_counter #(.LEN_W(LEN_W)) steps_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (arm),
    .tick (tick),
    .len  (len_q),
    .done (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      len_q    <= LEN_W'(RST_LEN);
    end else begin
      if (arm) len_q <= len_i;
      if (!flash_en_i)               active_q <= 1'b0;
      else if (frame_start_i)        active_q <= (len_i != '0);
      else if (readout_start_i)      active_q <= 1'b0;
      else if (done && len_q != HOLD_CODE) active_q <= 1'b0;
    end
  end

  assign strobe_o = active_q;
endmodule

// File: rtl/flash_strobe_chk.sv
module flash_strobe_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flash_en_i,
  input logic [LEN_W-1:0] len_i,
  input logic             frame_start_i,
  input logic             readout_start_i,
  input logic [LEN_W-1:0] len_q,
  input logic             strobe_o
);
  localparam logic [LEN_W-1:0] HOLD_CODE = '1;

  assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(frame_start_i && flash_en_i));

  assert_zero_len_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && flash_en_i && len_i == '0) |=> !strobe_o);

  assert_hold_until_readout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && len_q == HOLD_CODE && flash_en_i && !frame_start_i && !readout_start_i)
      |=> strobe_o);

  assert_readout_cuts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_start_i && !frame_start_i) |=> !strobe_o);

  assert_enable_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en_i |=> !strobe_o);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && flash_en_i && len_i != '0) |=> strobe_o);
endmodule

bind flash_strobe_timer flash_strobe_chk #(.LEN_W(LEN_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .flash_en_i     (flash_en_i),
  .len_i          (len_i),
  .frame_start_i  (frame_start_i),
  .readout_start_i(readout_start_i),
  .len_q          (len_q),
  .strobe_o       (strobe_o)
);

// File: tb/flash_strobe_timer_tb_top.sv
module flash_strobe_timer_tb_top;
  localparam int unsigned P = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flash_en_i = 1'b0;
  logic [7:0] len_i = 8'd0;
  logic       frame_start_i = 1'b0;
  logic       readout_start_i = 1'b0;
  logic       strobe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  flash_strobe_timer #(.LEN_W(8), .PRESCALE(P), .RST_LEN(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .flash_en_i(flash_en_i), .len_i(len_i),
    .frame_start_i(frame_start_i), .readout_start_i(readout_start_i),
    .strobe_o(strobe_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One frame: iteration i (from 1) is the i-th negedge after the start
  // strobe was sampled. Events given at iteration i take effect at the next edge.
  task automatic run_frame(input string req, input int len, input int ro_at,
                           input int dis_at, input int chg_at, input int chg_len,
                           input int rs_at, input int rs_len, input int exp);
    int width = 0;
    @(negedge clk);
    len_i = 8'(len);
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    for (int i = 1; i < 2000; i++) begin
      if (strobe_o !== 1'b1) break;
      width++;
      readout_start_i = (i == ro_at);
      frame_start_i   = (i == rs_at);
      if (i == rs_at) len_i = 8'(rs_len);
      if (i == chg_at) len_i = 8'(chg_len);
      if (i == dis_at) flash_en_i = 1'b0;
      @(negedge clk);
    end
    readout_start_i = 1'b0;
    frame_start_i = 1'b0;
    check(req, width, exp);
    flash_en_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 strobe low in reset", int'(strobe_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobe low after reset", int'(strobe_o), 0);

    // R6: enable low, frame start ignored
    flash_en_i = 1'b0;
    @(negedge clk);
    len_i = 8'd5; frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    check("R6 disabled start ignored", int'(strobe_o), 0);
    flash_en_i = 1'b1;
    @(negedge clk);

    // R2/R3 sweep of all timed lengths
    for (int l = 0; l < 255; l++)
      run_frame(l == 0 ? "R3 zero length" : "R2 timed width",
                l, 0, 0, 0, 0, 0, 0, l * P);

    // R4 hold until readout
    run_frame("R4 hold early readout", 255, 1, 0, 0, 0, 0, 0, 1);
    run_frame("R4 hold mid readout", 255, 7, 0, 0, 0, 0, 0, 7);
    run_frame("R4 hold late readout", 255, 900, 0, 0, 0, 0, 0, 900);

    // R5 readout cut around natural end
    for (int k = 0; k < 3; k++) begin
      int l = (k == 0) ? 1 : (k == 1) ? 5 : 40;
      int n = l * P;
      run_frame("R5 readout before end", l, n - 1 > 0 ? n - 1 : 1, 0, 0, 0, 0, 0,
                n - 1 > 0 ? n - 1 : 1);
      run_frame("R5 readout at end", l, n, 0, 0, 0, 0, 0, n);
      run_frame("R5 readout after end", l, n + 1, 0, 0, 0, 0, 0, n);
    end

    // R6 enable dropped mid-pulse
    run_frame("R6 enable drop mid", 20, 0, 3, 0, 0, 0, 0, 3);
    run_frame("R6 enable drop hold", 255, 0, 9, 0, 0, 0, 0, 9);

    // R7 length change mid-pulse, then next pulse uses new value
    run_frame("R7 mid change ignored", 6, 0, 0, 2, 30, 0, 0, 6 * P);
    run_frame("R7 next pulse new len", 30, 0, 0, 0, 0, 0, 0, 30 * P);

    // R8 restart during pulse
    run_frame("R8 restart full length", 10, 0, 0, 0, 0, 5, 10, 5 + 10 * P);
    run_frame("R8 restart shorter", 50, 0, 0, 0, 0, 3, 2, 3 + 2 * P);
    run_frame("R8 restart zero len", 50, 0, 0, 0, 0, 4, 0, 4);

    done_run = 1'b1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule